// File: doc/BRIEF.md
# Serial Transmit Line Controller

This block drives the transmit line of an asynchronous serial port. A CPU writes an 8-bit control register that holds interrupt enables, the transmitter and receiver enables, a receiver wakeup bit and a break request. It also writes characters into a one-deep data register. The transmitter moves each character into a shift register and places it on the line as a framed character. The line advances only on a one-cycle baud tick that a separate rate generator supplies.

Turning the transmitter on first sends a full character time of marking ones, so the far end can synchronise. Turning it off never cuts a frame short: the character already on the line always completes. An off-then-on toggle of the enable during a frame adds one all-ones character after the current frame. While the break bit is set, the block repeats break characters. A single interrupt request combines the gated empty and complete flags. The receive-side bits of the control register are stored and read back for the neighbouring receiver, but they have no effect here.

Top module: `sertx_top`

## Requirements
- R1: The control register resets to 0x00, takes `ctrl_wdata` on `ctrl_we` and reads back on `ctrl_q`. Its bit map is: bit 7 empty-interrupt enable, bit 6 complete-interrupt enable, bit 5 receive-full enable, bit 4 idle-line enable, bit 3 transmitter enable, bit 2 receiver enable, bit 1 receiver wakeup, bit 0 break request.
- R2: `txd` is 1 out of reset, and it stays 1 whenever no character is on the line.
- R3: A write that changes bit 3 from 0 to 1 schedules a character of all ones. Its length is 10 bit times with `nine_bit`=0 and 11 with `nine_bit`=1.
- R4: A data character is a 0 start bit, then the data bits least significant first (8 bits, or 9 when `nine_bit`=1, where the ninth bit is `data_wdata[8]`), then a 1 stop bit.
- R5: `txd` changes only on the clock edge that samples `baud_tick` high. Each bit lasts exactly one tick interval. A new character starts on the tick that follows the last bit of the previous one.
- R6: Clearing bit 3 during a character lets that character finish. After that, `txd` stays 1 and a waiting data character stays in the data register.
- R7: Clearing and then setting bit 3 during a character sends one all-ones character right after the current one.
- R8: While bits 0 and 3 are both set, the line repeats break characters. Each one is 10 (or 11) zero bits followed by one 1 bit.
- R9: `tx_empty` is 1 after reset. It goes 0 in the cycle after a data write. It returns to 1 on the tick that moves the data into the shifter.
- R10: `tx_done` is 1 only when no character is on the line and nothing is pending: no ones character, no break request with the transmitter on, and no data.
- R11: `tx_irq` = (`tx_empty` AND bit 7) OR (`tx_done` AND bit 6). Bits 5, 4, 2 and 1 have no effect on `txd` or `tx_irq`.
- R12: When a character may start, a pending ones character is chosen first, then a break, then data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write value |
| data_we | input | 1 | Data register write strobe |
| data_wdata | input | 9 | Character to send; bit 8 is used in 9-bit mode |
| nine_bit | input | 1 | 1 selects 9 data bits per character |
| baud_tick | input | 1 | One-cycle bit-rate pulse |
| ctrl_q | output | 8 | Control register readback |
| txd | output | 1 | Serial transmit line |
| tx_empty | output | 1 | Data register can take a new character |
| tx_done | output | 1 | Line and all queues idle |
| tx_irq | output | 1 | Gated transmit interrupt request |

## Verification
The hardest case to reach is the enable toggle that lands inside a frame. The clear and the set must both arrive while the shifter still has bits left, and a data character must already be waiting so the ordering can be seen. The stimulus writes two characters, waits a few ticks into the first, and then issues the two control writes on consecutive cycles. The same scheme, with only the clear, covers the graceful stop. A behavioural queue model, compared every cycle, shows which character comes out next.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
   typedef enum logic [1:0] {
      JOB_NONE  = 2'd0,
      JOB_ONES  = 2'd1,
      JOB_BREAK = 2'd2,
      JOB_DATA  = 2'd3
   } job_e;

   localparam int CTRL_W    = 8;
   localparam int CB_EMP_IE = 7;
   localparam int CB_CMP_IE = 6;
   localparam int CB_RXF_IE = 5;
   localparam int CB_IDL_IE = 4;
   localparam int CB_TXEN   = 3;
   localparam int CB_RXEN   = 2;
   localparam int CB_WAKE   = 1;
   localparam int CB_BRK    = 0;
endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
   import sertx_pkg::*;
#(
   parameter int CW = CTRL_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [CW-1:0] wr_data,
   output logic [CW-1:0] ctrl_q,
   output logic          txen,
   output logic          brk,
   output logic          txen_rise
);
   generate
      if (CW != 8) begin : g_bad_cw
         $error("sertx_ctrl: control register must be 8 bits");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= '0;
      else if (wr_en) ctrl_q <= wr_data;
   end

   assign txen      = ctrl_q[CB_TXEN];
   assign brk       = ctrl_q[CB_BRK];
   assign txen_rise = wr_en && wr_data[CB_TXEN] && !ctrl_q[CB_TXEN];

   // R1: a write is visible on the readback one cycle later
   a_r1_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ctrl_q == $past(wr_data)));
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
   parameter int DW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          take,
   output logic [DW-1:0] hold_q,
   output logic          empty
);
   generate
      if (DW < 2) begin : g_bad_dw
         $error("sertx_hold: data width too small");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         empty  <= 1'b1;
      end else if (wr_en) begin
         hold_q <= wr_data;
         empty  <= 1'b0;
      end else if (take) begin
         empty  <= 1'b1;
      end
   end

   // R9: the shifter only takes data while the register holds some
   a_r9_take_only_full: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> !empty);
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
   import sertx_pkg::*;
#(
   parameter int BASE_W = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          txen,
   input  logic          nine,
   input  logic          ones_pend,
   input  logic          brk,
   input  logic          full,
   input  logic [BASE_W:0] hold,
   output logic          take_data,
   output logic          take_ones,
   output logic          txd,
   output logic          active
);
   localparam int DW    = BASE_W + 1;
   localparam int FMAX  = BASE_W + 4;
   localparam int CNT_W = $clog2(FMAX + 1);

   generate
      if (BASE_W < 5) begin : g_bad_base
         $error("sertx_shift: base width below 5");
      end
   endgenerate

   job_e              job;
   logic [CNT_W-1:0]  frame_len;
   logic [CNT_W-1:0]  left;
   logic [FMAX-1:0]   sh;
   logic [FMAX-1:0]   frame;
   logic [CNT_W-1:0]  load_len;
   logic              load;

   always_comb begin
      if (ones_pend)  job = JOB_ONES;
      else if (brk)   job = JOB_BREAK;
      else if (full)  job = JOB_DATA;
      else            job = JOB_NONE;
   end

   assign frame_len = nine ? CNT_W'(BASE_W + 3) : CNT_W'(BASE_W + 2);

   always_comb begin
      frame    = '1;
      load_len = frame_len;
      case (job)
         JOB_BREAK: begin
            for (int i = 0; i < FMAX; i++) frame[i] = (i == int'(frame_len));
            load_len = frame_len + CNT_W'(1);
         end
         JOB_DATA: begin
            frame[0] = 1'b0;
            for (int i = 0; i < DW; i++)
               if (i < BASE_W || nine) frame[1 + i] = hold[i];
         end
         default: ;
      endcase
   end

   assign load      = tick && (left == '0) && txen && (job != JOB_NONE);
   assign take_data = load && (job == JOB_DATA);
   assign take_ones = load && (job == JOB_ONES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh     <= '0;
         left   <= '0;
         txd    <= 1'b1;
         active <= 1'b0;
      end else if (tick) begin
         if (left != '0) begin
            txd  <= sh[0];
            sh   <= sh >> 1;
            left <= left - CNT_W'(1);
         end else if (load) begin
            txd    <= frame[0];
            sh     <= frame >> 1;
            left   <= load_len - CNT_W'(1);
            active <= 1'b1;
         end else begin
            txd    <= 1'b1;
            active <= 1'b0;
         end
      end
   end

   // R5: the line holds its level between ticks
   a_r5_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(txd));
   // R6: with the transmitter off, an ended frame leaves the line idle
   a_r6_off_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !txen && left == '0) |=> (!active && txd));
   // R12: ones character wins over any data take
   a_r12_ones_first: assert property (@(posedge clk) disable iff (!rst_n)
      ones_pend |-> !take_data);
endmodule

// File: rtl/sertx_top.sv
module sertx_top
   import sertx_pkg::*;
#(
   parameter int BASE_W  = 8,
   parameter bit REG_IRQ = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [7:0]        ctrl_wdata,
   input  logic              data_we,
   input  logic [BASE_W:0]   data_wdata,
   input  logic              nine_bit,
   input  logic              baud_tick,
   output logic [7:0]        ctrl_q,
   output logic              txd,
   output logic              tx_empty,
   output logic              tx_done,
   output logic              tx_irq
);
   logic txen, brk, txen_rise;
   logic take_data, take_ones, active;
   logic ones_pend;
   logic [BASE_W:0] hold_q;
   logic irq_now;

   sertx_ctrl #(.CW(CTRL_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(ctrl_we), .wr_data(ctrl_wdata),
      .ctrl_q(ctrl_q), .txen(txen), .brk(brk), .txen_rise(txen_rise)
   );

   sertx_hold #(.DW(BASE_W + 1)) u_hold (
      .clk(clk), .rst_n(rst_n), .wr_en(data_we), .wr_data(data_wdata),
      .take(take_data), .hold_q(hold_q), .empty(tx_empty)
   );

   sertx_shift #(.BASE_W(BASE_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .txen(txen), .nine(nine_bit),
      .ones_pend(ones_pend), .brk(brk), .full(!tx_empty), .hold(hold_q),
      .take_data(take_data), .take_ones(take_ones), .txd(txd), .active(active)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ones_pend <= 1'b0;
      else if (txen_rise)  ones_pend <= 1'b1;
      else if (!txen)      ones_pend <= 1'b0;
      else if (take_ones)  ones_pend <= 1'b0;
   end

   assign tx_done = !active && !ones_pend && tx_empty && !(txen && brk);
   assign irq_now = (tx_empty && ctrl_q[CB_EMP_IE]) || (tx_done && ctrl_q[CB_CMP_IE]);

   generate
      if (REG_IRQ) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_now;
         end
         assign tx_irq = irq_q;
         // R11: request follows gating one cycle late
         a_r11_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
            !(ctrl_q[CB_EMP_IE] || ctrl_q[CB_CMP_IE]) |=> !tx_irq);
      end else begin : g_irq_comb
         assign tx_irq = irq_now;
         // R11: no request without an enabled source
         a_r11_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
            !(ctrl_q[CB_EMP_IE] || ctrl_q[CB_CMP_IE]) |-> !tx_irq);
      end
   endgenerate

   // R2: nothing on the line means marking level
   a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> txd);
   // R9: a data write empties nothing; the flag drops next cycle
   a_r9_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
      data_we |=> !tx_empty);
endmodule

// File: tb/tb_sertx_top.sv
module tb_sertx_top;
   localparam int DIV = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctrl_we = 1'b0;
   logic [7:0] ctrl_wdata = 8'h00;
   logic       data_we = 1'b0;
   logic [8:0] data_wdata = 9'h000;
   logic       nine_bit = 1'b0;
   logic       baud_tick = 1'b0;
   logic [7:0] ctrl_q;
   logic       txd, tx_empty, tx_done, tx_irq;

   int n_cmp = 0;
   int n_bad = 0;
   string tag = "R2";
   int tcnt = 0;
   bit finished = 1'b0;

   sertx_top dut (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .data_we(data_we), .data_wdata(data_wdata), .nine_bit(nine_bit),
      .baud_tick(baud_tick), .ctrl_q(ctrl_q), .txd(txd), .tx_empty(tx_empty),
      .tx_done(tx_done), .tx_irq(tx_irq)
   );

   always #5 clk = ~clk;

   always @(negedge clk) begin
      baud_tick = (tcnt == DIV - 1);
      tcnt = (tcnt + 1) % DIV;
   end

   // behavioural reference model
   bit        q[$];
   bit        m_txd = 1'b1, m_act = 1'b0, m_empty = 1'b1, m_pend = 1'b0;
   logic [7:0] m_ctrl = 8'h00;
   logic [8:0] m_hold = 9'h000;
   bit        m_done, m_irq;

   task automatic check(input string what, input logic [8:0] got, input logic [8:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h at %0t", tag, what, got, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         m_txd = 1; m_act = 0; m_empty = 1; m_pend = 0; m_ctrl = 0; m_hold = 0;
      end else begin
         bit te, took_data, took_ones;
         int len;
         te = m_ctrl[3];
         took_data = 0; took_ones = 0;
         len = nine_bit ? 11 : 10;
         if (baud_tick) begin
            if (q.size() > 0) m_txd = q.pop_front();
            else if (te && (m_pend || m_ctrl[0] || !m_empty)) begin
               if (m_pend) begin
                  for (int i = 0; i < len; i++) q.push_back(1'b1);
                  took_ones = 1;
               end else if (m_ctrl[0]) begin
                  for (int i = 0; i < len; i++) q.push_back(1'b0);
                  q.push_back(1'b1);
               end else begin
                  q.push_back(1'b0);
                  for (int i = 0; i < len - 2; i++) q.push_back(m_hold[i]);
                  q.push_back(1'b1);
                  took_data = 1;
               end
               m_txd = q.pop_front();
               m_act = 1;
            end else begin
               m_txd = 1; m_act = 0;
            end
         end
         if (ctrl_we && ctrl_wdata[3] && !te) m_pend = 1;
         else if (!te) m_pend = 0;
         else if (took_ones) m_pend = 0;
         if (data_we) begin m_hold = data_wdata; m_empty = 0; end
         else if (took_data) m_empty = 1;
         if (ctrl_we) m_ctrl = ctrl_wdata;
      end
      m_done = !m_act && !m_pend && m_empty && !(m_ctrl[3] && m_ctrl[0]);
      m_irq  = (m_empty && m_ctrl[7]) || (m_done && m_ctrl[6]);
      #1;
      if (rst_n && !finished) begin
         check("txd R4 R5", {8'h0, txd}, {8'h0, m_txd});
         check("tx_empty R9", {8'h0, tx_empty}, {8'h0, m_empty});
         check("tx_done R10", {8'h0, tx_done}, {8'h0, m_done});
         check("tx_irq R11", {8'h0, tx_irq}, {8'h0, m_irq});
         check("ctrl_q R1", {1'b0, ctrl_q}, {1'b0, m_ctrl});
      end
   end

   task automatic wr_ctrl(input logic [7:0] v);
      @(negedge clk); ctrl_we = 1; ctrl_wdata = v;
      @(negedge clk); ctrl_we = 0;
   endtask

   task automatic wr_data(input logic [8:0] v);
      @(negedge clk); data_we = 1; data_wdata = v;
      @(negedge clk); data_we = 0;
   endtask

   task automatic wait_ticks(input int n);
      repeat (n * DIV) @(posedge clk);
   endtask

   task automatic finish_run();
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      tag = "R1";  check("reset ctrl_q", {1'b0, ctrl_q}, 9'h000);
      tag = "R2";  check("reset txd", {8'h0, txd}, 9'h001);
      tag = "R9";  check("reset tx_empty", {8'h0, tx_empty}, 9'h001);
      tag = "R10"; check("reset tx_done", {8'h0, tx_done}, 9'h001);

      tag = "R3";  wr_ctrl(8'hC8);          // TE with both irq enables
      wait_ticks(3);
      tag = "R4";  wr_data(9'h0A5);
      wait_ticks(14);
      wr_data(9'h03C);
      wait_ticks(13);

      tag = "R3";  wr_ctrl(8'hC0); wait_ticks(2);
      nine_bit = 1; wr_ctrl(8'hC8);
      tag = "R4";  wr_data(9'h13C);
      wait_ticks(26);

      tag = "R6";  nine_bit = 0;
      wr_data(9'h055); wait_ticks(1); wr_data(9'h0F0);
      wait_ticks(3); wr_ctrl(8'hC0);
      wait_ticks(18);
      check("pending data kept", {8'h0, tx_empty}, 9'h000);
      wr_ctrl(8'hC8); wait_ticks(24);

      tag = "R7";  wr_data(9'h081); wait_ticks(1); wr_data(9'h07E);
      wait_ticks(4); wr_ctrl(8'hC0); wr_ctrl(8'hC8);
      tag = "R12"; wait_ticks(36);

      tag = "R8";  wr_ctrl(8'hC9); wr_data(9'h011);
      wait_ticks(30);
      wr_ctrl(8'hC8); wait_ticks(26);

      tag = "R11"; wr_ctrl(8'h3E); wait_ticks(4);
      check("irq masked", {8'h0, tx_irq}, 9'h000);
      wr_data(9'h0C3); wait_ticks(14);
      wr_ctrl(8'h48); wait_ticks(4);
      wr_ctrl(8'h88); wr_data(9'h1FF); wait_ticks(14);
      finish_run();
   end
endmodule